// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a processor's memory port and decides, for every access, whether it may proceed. Software fills a small table of protection regions through a register write port. Each region has a size-aligned base address, a power-of-two size, separate read, write and execute permissions, a flag that limits it to privileged code, an enable bit, and a mask that removes any of its eight equal sub-regions from the region. A single global enable turns protection on or off.

An access presents an address, a kind (read, write or instruction fetch) and a privilege flag. The allow or fault decision is combinational, in the same cycle as the request. When several regions cover the address, the one with the highest index decides. The first fault is latched into sticky status registers that hold the address, the kind and the privilege level. Later faults leave these registers alone until software clears them.

Top module: `memguard_top`

## Requirements
- R1: After reset, every region is disabled, global protection is off and `flt_valid` is 0. While global protection is off, every valid access is allowed.
- R2: A region with size code k covers the addresses from its base up to base + 2^k - 1. A configuration write forces the low k bits of the base to zero.
- R3: The access kind picks the permission bit that is checked: code 0 is a read (read bit), code 1 is a write (write bit), code 2 is an instruction fetch (execute bit), and code 3 is checked as a read.
- R4: When the deciding region is marked privileged-only, an access with `acc_priv`=0 faults whatever its permission bits say.
- R5: The sub-region of an address is address bits [k-1:k-3]. When bit j of a region's disable mask is 1, addresses in sub-region j do not match that region.
- R6: When several enabled regions match, only the highest-numbered one decides the outcome. A disabled sub-region of a higher region lets a lower region decide.
- R7: With protection on, an access that matches no region is allowed when `acc_priv`=1 and faults when `acc_priv`=0.
- R8: `acc_allow` and `acc_fault` follow the access inputs in the same cycle, and both are 0 while `acc_valid` is 0.
- R9: The first fault sets `flt_valid` on the next clock edge and records its address, kind and privilege. Later faults change nothing until `flt_clr` is asserted. The clear drops `flt_valid` at the next edge.
- R10: A configuration write whose size code is below 8 or above 32 changes nothing in the region table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_idx | input | 3 | Index of the region being written |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 6 | Region size code k (2^k bytes, 8..32) |
| cfg_rd | input | 1 | Read permission |
| cfg_wr | input | 1 | Write permission |
| cfg_ex | input | 1 | Execute permission |
| cfg_priv_only | input | 1 | Region reserved for privileged accesses |
| cfg_sub_dis | input | 8 | Sub-region disable mask |
| cfg_en | input | 1 | Region enable |
| ctl_we | input | 1 | Global enable write strobe |
| ctl_en | input | 1 | Global protection enable value |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | Access kind code |
| acc_priv | input | 1 | Access is privileged |
| flt_clr | input | 1 | Clear the sticky fault status |
| acc_allow | output | 1 | Access permitted (combinational) |
| acc_fault | output | 1 | Access denied (combinational) |
| flt_valid | output | 1 | Sticky fault status valid |
| flt_addr | output | 32 | Address of the recorded fault |
| flt_kind | output | 2 | Kind of the recorded fault |
| flt_priv | output | 1 | Privilege of the recorded fault |

## Verification
The assertions assume that the access inputs are stable while the clock edge samples them. They also assume that the configuration port is driven with defined values whenever `cfg_we` is high, so the stored base is always aligned to the stored size code. The bench drives every input a short time after the rising edge, and every configuration it sends either carries a legal size code or is an intentional out-of-range code aimed at R10. The random accesses are drawn from a fixed seed and mostly land inside configured regions, so boundaries, sub-regions and overlaps are hit often. Directed cases cover the edges of a region, the full-space size and clear ordering.

// File: rtl/memguard_pkg.sv
package memguard_pkg;

  localparam int SUBS      = 8;
  localparam int SUB_IDX_W = 3;

  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_EX  = 2'd2,
    KIND_RSV = 2'd3
  } acc_kind_e;

  // permission vector layout: {ex, wr, rd}
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

endpackage

// File: rtl/memguard_region_cfg.sv
module memguard_region_cfg
  import memguard_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int MIN_LOG2    = 8,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int SZW        = $clog2(ADDR_W + 1)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cfg_we,
  input  logic [IDX_W-1:0]                     cfg_idx,
  input  logic [ADDR_W-1:0]                    cfg_base,
  input  logic [SZW-1:0]                       cfg_size,
  input  logic [2:0]                           cfg_perm,
  input  logic                                 cfg_priv_only,
  input  logic [SUBS-1:0]                      cfg_sub_dis,
  input  logic                                 cfg_en,
  input  logic                                 ctl_we,
  input  logic                                 ctl_en,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   reg_base,
  output logic [NUM_REGIONS-1:0][SZW-1:0]      reg_size,
  output logic [NUM_REGIONS-1:0][2:0]          reg_perm,
  output logic [NUM_REGIONS-1:0]               reg_priv_only,
  output logic [NUM_REGIONS-1:0][SUBS-1:0]     reg_sub_dis,
  output logic [NUM_REGIONS-1:0]               reg_en,
  output logic                                 gbl_en
);

  function automatic logic [ADDR_W-1:0] low_mask(input logic [SZW-1:0] k);
    logic [ADDR_W:0] one_hot;
    one_hot = (ADDR_W+1)'(1) << k;
    return one_hot[ADDR_W-1:0] - ADDR_W'(1);
  endfunction

  logic size_ok;
  logic idx_ok;

  assign size_ok = (cfg_size >= SZW'(MIN_LOG2)) && (cfg_size <= SZW'(ADDR_W));
  assign idx_ok  = (int'(cfg_idx) < NUM_REGIONS);

  always_ff @(posedge clk) begin
    if (rst) gbl_en <= 1'b0;
    else if (ctl_we) gbl_en <= ctl_en;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    always_ff @(posedge clk) begin
      if (rst) begin
        reg_base[g]      <= '0;
        reg_size[g]      <= SZW'(MIN_LOG2);
        reg_perm[g]      <= '0;
        reg_priv_only[g] <= 1'b0;
        reg_sub_dis[g]   <= '0;
        reg_en[g]        <= 1'b0;
      end else if (cfg_we && size_ok && idx_ok && (int'(cfg_idx) == g)) begin
        reg_base[g]      <= cfg_base & ~low_mask(cfg_size);
        reg_size[g]      <= cfg_size;
        reg_perm[g]      <= cfg_perm;
        reg_priv_only[g] <= cfg_priv_only;
        reg_sub_dis[g]   <= cfg_sub_dis;
        reg_en[g]        <= cfg_en;
      end
    end

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      (reg_base[g] & low_mask(reg_size[g])) == '0); // R2

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (reg_size[g] >= SZW'(MIN_LOG2)) && (reg_size[g] <= SZW'(ADDR_W))); // R10
  end

endmodule

// File: rtl/memguard_match.sv
module memguard_match
  import memguard_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int SZW   = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SZW-1:0]    size,
  input  logic [SUBS-1:0]   sub_dis,
  input  logic              en,
  output logic              hit
);

  logic [ADDR_W:0]        one_hot;
  logic [ADDR_W-1:0]      span_mask;
  logic [SZW-1:0]         sub_shift;
  logic [SUB_IDX_W-1:0]   sub_idx;
  logic                   in_range;

  always_comb begin
    one_hot   = (ADDR_W+1)'(1) << size;
    span_mask = one_hot[ADDR_W-1:0] - ADDR_W'(1);
    sub_shift = size - SZW'(SUB_IDX_W);
    sub_idx   = SUB_IDX_W'(acc_addr >> sub_shift);
    in_range  = ((acc_addr & ~span_mask) == base);
    hit       = en && in_range && !sub_dis[sub_idx];
  end

endmodule

// File: rtl/memguard_decide.sv
module memguard_decide
  import memguard_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        gbl_en,
  input  logic [NUM_REGIONS-1:0]      hits,
  input  logic [NUM_REGIONS-1:0][2:0] perm,
  input  logic [NUM_REGIONS-1:0]      priv_only,
  input  logic                        acc_valid,
  input  logic [1:0]                  acc_kind,
  input  logic                        acc_priv,
  output logic                        acc_allow,
  output logic                        acc_fault
);

  logic       any_hit;
  logic [2:0] sel_perm;
  logic       sel_priv_only;
  logic       kind_ok;
  logic       permitted;

  // ascending scan: the last hit seen, i.e. the highest index, wins
  always_comb begin
    any_hit       = 1'b0;
    sel_perm      = '0;
    sel_priv_only = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hits[i]) begin
        any_hit       = 1'b1;
        sel_perm      = perm[i];
        sel_priv_only = priv_only[i];
      end
    end
  end

  always_comb begin
    unique case (acc_kind_e'(acc_kind))
      KIND_WR: kind_ok = sel_perm[PERM_WR];
      KIND_EX: kind_ok = sel_perm[PERM_EX];
      default: kind_ok = sel_perm[PERM_RD];
    endcase
  end

  always_comb begin
    if (!gbl_en)       permitted = 1'b1;
    else if (!any_hit) permitted = acc_priv;
    else               permitted = kind_ok && (acc_priv || !sel_priv_only);
  end

  assign acc_allow = acc_valid && permitted;
  assign acc_fault = acc_valid && !permitted;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (!acc_allow && !acc_fault)); // R8

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    (!gbl_en && acc_valid) |-> acc_allow); // R1

  AST_NOMATCH_UNPRIV: assert property (@(posedge clk) disable iff (rst)
    (gbl_en && acc_valid && (hits == '0) && !acc_priv) |-> acc_fault); // R7

  AST_NOMATCH_PRIV: assert property (@(posedge clk) disable iff (rst)
    (gbl_en && acc_valid && (hits == '0) && acc_priv) |-> acc_allow); // R7

  AST_PRIV_ONLY: assert property (@(posedge clk) disable iff (rst)
    (gbl_en && acc_valid && any_hit && sel_priv_only && !acc_priv) |-> acc_fault); // R4

endmodule

// File: rtl/memguard_fault_status.sv
module memguard_fault_status #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  input  logic              priv,
  input  logic              clr,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [1:0]        flt_kind,
  output logic              flt_priv
);

  logic capture;
  assign capture = fault && (!flt_valid || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_kind  <= '0;
      flt_priv  <= 1'b0;
    end else begin
      if (clr) flt_valid <= 1'b0;
      if (capture) begin
        flt_valid <= 1'b1;
        flt_addr  <= addr;
        flt_kind  <= kind;
        flt_priv  <= priv;
      end
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !clr) |=> (flt_valid && $stable(flt_addr) && $stable(flt_kind) && $stable(flt_priv))); // R9

  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (fault && !flt_valid) |=> (flt_valid && flt_addr == $past(addr) && flt_kind == $past(kind))); // R9

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !fault) |=> !flt_valid); // R9

endmodule

// File: rtl/memguard_top.sv
module memguard_top
  import memguard_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int MIN_LOG2    = 8,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int SZW        = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZW-1:0]    cfg_size,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic              cfg_ex,
  input  logic              cfg_priv_only,
  input  logic [7:0]        cfg_sub_dis,
  input  logic              cfg_en,
  input  logic              ctl_we,
  input  logic              ctl_en,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  input  logic              flt_clr,
  output logic              acc_allow,
  output logic              acc_fault,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [1:0]        flt_kind,
  output logic              flt_priv
);

  logic [NUM_REGIONS-1:0][ADDR_W-1:0] reg_base;
  logic [NUM_REGIONS-1:0][SZW-1:0]    reg_size;
  logic [NUM_REGIONS-1:0][2:0]        reg_perm;
  logic [NUM_REGIONS-1:0]             reg_priv_only;
  logic [NUM_REGIONS-1:0][SUBS-1:0]   reg_sub_dis;
  logic [NUM_REGIONS-1:0]             reg_en;
  logic [NUM_REGIONS-1:0]             hits;
  logic                               gbl_en;

  memguard_region_cfg #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .MIN_LOG2(MIN_LOG2)
  ) cfg_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_perm({cfg_ex, cfg_wr, cfg_rd}), .cfg_priv_only(cfg_priv_only),
    .cfg_sub_dis(cfg_sub_dis), .cfg_en(cfg_en),
    .ctl_we(ctl_we), .ctl_en(ctl_en),
    .reg_base(reg_base), .reg_size(reg_size), .reg_perm(reg_perm),
    .reg_priv_only(reg_priv_only), .reg_sub_dis(reg_sub_dis), .reg_en(reg_en),
    .gbl_en(gbl_en)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    memguard_match #(.ADDR_W(ADDR_W)) match_i (
      .acc_addr(acc_addr),
      .base(reg_base[g]),
      .size(reg_size[g]),
      .sub_dis(reg_sub_dis[g]),
      .en(reg_en[g]),
      .hit(hits[g])
    );
  end

  memguard_decide #(.NUM_REGIONS(NUM_REGIONS)) decide_i (
    .clk(clk), .rst(rst), .gbl_en(gbl_en), .hits(hits),
    .perm(reg_perm), .priv_only(reg_priv_only),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .acc_allow(acc_allow), .acc_fault(acc_fault)
  );

  memguard_fault_status #(.ADDR_W(ADDR_W)) status_i (
    .clk(clk), .rst(rst), .fault(acc_fault), .addr(acc_addr),
    .kind(acc_kind), .priv(acc_priv), .clr(flt_clr),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_kind(flt_kind), .flt_priv(flt_priv)
  );

endmodule

// File: tb/memguard_top_tb_top.sv
module memguard_top_tb_top;

  localparam int AW = 32;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we, cfg_rd, cfg_wr, cfg_ex, cfg_priv_only, cfg_en;
  logic [2:0] cfg_idx;
  logic [AW-1:0] cfg_base;
  logic [5:0] cfg_size;
  logic [7:0] cfg_sub_dis;
  logic ctl_we, ctl_en, acc_valid, acc_priv, flt_clr;
  logic [AW-1:0] acc_addr;
  logic [1:0] acc_kind;
  logic acc_allow, acc_fault, flt_valid, flt_priv;
  logic [AW-1:0] flt_addr;
  logic [1:0] flt_kind;

  always #10 clk = ~clk;

  memguard_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_ex(cfg_ex),
    .cfg_priv_only(cfg_priv_only), .cfg_sub_dis(cfg_sub_dis), .cfg_en(cfg_en),
    .ctl_we(ctl_we), .ctl_en(ctl_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_priv(acc_priv), .flt_clr(flt_clr),
    .acc_allow(acc_allow), .acc_fault(acc_fault), .flt_valid(flt_valid),
    .flt_addr(flt_addr), .flt_kind(flt_kind), .flt_priv(flt_priv)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model of the region table and status
  bit [AW-1:0] m_base [NR];
  int          m_size [NR];
  bit [2:0]    m_perm [NR];
  bit          m_po   [NR];
  bit [7:0]    m_sd   [NR];
  bit          m_en   [NR];
  bit          m_gbl;
  bit          m_fv;
  bit [AW-1:0] m_fa;
  bit [1:0]    m_fk;
  bit          m_fp;

  function automatic bit [AW-1:0] span(int k);
    return AW'((64'd1 << k) - 64'd1);
  endfunction

  function automatic bit exp_allow(bit [AW-1:0] a, bit [1:0] kind, bit priv);
    bit hit = 0;
    bit [2:0] p = 0;
    bit po = 0;
    bit ok;
    if (!m_gbl) return 1'b1;
    for (int i = 0; i < NR; i++) begin
      int sub = int'((64'(a) >> (m_size[i] - 3)) & 64'd7);
      if (m_en[i] && ((a & ~span(m_size[i])) == m_base[i]) && !m_sd[i][sub]) begin
        hit = 1; p = m_perm[i]; po = m_po[i];
      end
    end
    if (!hit) return priv;
    ok = (kind == 2'd1) ? p[1] : (kind == 2'd2) ? p[2] : p[0];
    return ok && (priv || !po);
  endfunction

  task automatic chk(bit cond, string req, string what, longint act, longint expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic cfg_write(int idx, bit [AW-1:0] base, int size, bit [2:0] perm,
                           bit po, bit [7:0] sd, bit en);
    cfg_idx = 3'(idx); cfg_base = base; cfg_size = 6'(size);
    {cfg_ex, cfg_wr, cfg_rd} = perm; cfg_priv_only = po; cfg_sub_dis = sd; cfg_en = en;
    cfg_we = 1'b1;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    if (size >= 8 && size <= 32) begin
      m_base[idx] = base & ~span(size); m_size[idx] = size; m_perm[idx] = perm;
      m_po[idx] = po; m_sd[idx] = sd; m_en[idx] = en;
    end
  endtask

  task automatic set_gbl(bit v);
    ctl_en = v; ctl_we = 1'b1;
    @(posedge clk); #2;
    ctl_we = 1'b0; m_gbl = v;
  endtask

  task automatic access(bit [AW-1:0] a, bit [1:0] kind, bit priv, string req);
    bit e;
    acc_addr = a; acc_kind = kind; acc_priv = priv; acc_valid = 1'b1;
    e = exp_allow(a, kind, priv);
    #5;
    chk(acc_allow == e && acc_fault == !e, req, "allow/fault", {acc_allow, acc_fault}, {e, !e});
    @(posedge clk); #2;
    acc_valid = 1'b0;
    if (!e && !m_fv) begin
      m_fv = 1; m_fa = a; m_fk = kind; m_fp = priv;
    end
  endtask

  task automatic check_status(string req);
    chk(flt_valid == m_fv, req, "flt_valid", flt_valid, m_fv);
    if (m_fv) begin
      chk(flt_addr == m_fa, req, "flt_addr", flt_addr, m_fa);
      chk(flt_kind == m_fk && flt_priv == m_fp, req, "flt_kind/priv",
          {flt_kind, flt_priv}, {m_fk, m_fp});
    end
  endtask

  task automatic clear_fault();
    flt_clr = 1'b1;
    @(posedge clk); #2;
    flt_clr = 1'b0; m_fv = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst = 1; cfg_we = 0; ctl_we = 0; ctl_en = 0; acc_valid = 0; flt_clr = 0;
    cfg_idx = 0; cfg_base = 0; cfg_size = 0; cfg_rd = 0; cfg_wr = 0; cfg_ex = 0;
    cfg_priv_only = 0; cfg_sub_dis = 0; cfg_en = 0; acc_addr = 0; acc_kind = 0; acc_priv = 0;
    for (int i = 0; i < NR; i++) begin
      m_base[i] = 0; m_size[i] = 8; m_perm[i] = 0; m_po[i] = 0; m_sd[i] = 0; m_en[i] = 0;
    end
    m_gbl = 0; m_fv = 0; m_fa = 0; m_fk = 0; m_fp = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;

    // R1: reset state, protection off allows everything
    chk(flt_valid == 0, "R1", "flt_valid after reset", flt_valid, 0);
    access(32'hDEAD_BEEF, 2'd1, 1'b0, "R1");
    access(32'h0000_0000, 2'd2, 1'b0, "R1");
    // R8: idle request gives neither output
    #5 chk(!acc_allow && !acc_fault, "R8", "idle outputs", {acc_allow, acc_fault}, 0);
    @(posedge clk); #2;

    // R7 / R9: no region, unprivileged faults and is captured
    set_gbl(1);
    access(32'h0000_4000, 2'd0, 1'b1, "R7");
    access(32'h0000_5004, 2'd1, 1'b0, "R7");
    check_status("R9");
    access(32'h0000_6008, 2'd2, 1'b0, "R9");
    check_status("R9");
    clear_fault();
    check_status("R9");

    // R2 / R3: 4 KB read-only region, base given misaligned
    cfg_write(0, 32'h0000_1234, 12, 3'b001, 0, 8'h00, 1);
    access(32'h0000_1000, 2'd0, 1'b0, "R2");
    access(32'h0000_1FFF, 2'd0, 1'b0, "R2");
    access(32'h0000_2000, 2'd0, 1'b0, "R2");
    clear_fault();
    access(32'h0000_1800, 2'd1, 1'b0, "R3");
    access(32'h0000_1800, 2'd2, 1'b1, "R3");
    access(32'h0000_1800, 2'd3, 1'b0, "R3");
    clear_fault();

    // R4: privileged-only region with full permissions
    cfg_write(4, 32'h0080_0000, 16, 3'b111, 1, 8'h00, 1);
    access(32'h0080_0010, 2'd0, 1'b0, "R4");
    access(32'h0080_0010, 2'd2, 1'b1, "R4");
    clear_fault();

    // R5: 64 KB region, sub-region 2 disabled
    cfg_write(1, 32'h0001_0000, 16, 3'b111, 0, 8'h04, 1);
    access(32'h0001_4000, 2'd0, 1'b0, "R5");
    access(32'h0001_4000, 2'd0, 1'b1, "R5");
    access(32'h0001_6000, 2'd1, 1'b0, "R5");
    clear_fault();

    // R6: higher index write-only region overlaps region 1
    cfg_write(2, 32'h0001_0000, 13, 3'b010, 0, 8'h00, 1);
    access(32'h0001_0100, 2'd0, 1'b0, "R6");
    access(32'h0001_0100, 2'd1, 1'b0, "R6");
    cfg_write(2, 32'h0001_0000, 13, 3'b010, 0, 8'h01, 1);
    access(32'h0001_0100, 2'd0, 1'b0, "R6");
    clear_fault();

    // R10: out-of-range size codes leave region 0 untouched
    cfg_write(0, 32'h0000_1000, 4, 3'b000, 0, 8'hFF, 0);
    cfg_write(0, 32'h0000_1000, 33, 3'b000, 0, 8'hFF, 0);
    access(32'h0000_1100, 2'd0, 1'b0, "R10");
    access(32'h0000_1100, 2'd1, 1'b0, "R10");
    clear_fault();

    // R2: full-space region at size code 32 in slot 7, execute only
    cfg_write(7, 32'hFFFF_FFFF, 32, 3'b100, 0, 8'h00, 1);
    access(32'hFFFF_FFF0, 2'd2, 1'b0, "R2");
    access(32'h1234_5678, 2'd0, 1'b0, "R2");
    cfg_write(7, 32'h0, 32, 3'b100, 0, 8'h00, 0);
    clear_fault();

    // random phase
    for (int i = 0; i < NR; i++)
      cfg_write(i, $urandom, 8 + int'($urandom % 13), 3'($urandom), 1'($urandom),
                8'($urandom % 4 == 0 ? $urandom : 0), 1'($urandom % 4 != 0));
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % NR);
      bit [AW-1:0] a = ($urandom % 4 != 0) ? (m_base[r] | ($urandom & span(m_size[r])))
                                            : AW'($urandom);
      if (n % 400 == 399)
        cfg_write(int'($urandom % NR), $urandom, 8 + int'($urandom % 26), 3'($urandom),
                  1'($urandom), 8'($urandom), 1'($urandom));
      access(a, 2'($urandom), 1'($urandom), "R6");
      check_status("R9");
      if ($urandom % 16 == 0) clear_fault();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule